// File: doc/BRIEF.md
# Pushbutton Single-Step Pulse Generator

This block turns each press of a pushbutton into exactly one enable pulse, one period of the fast system clock wide. The pulse lasts one cycle however long the button is held. Downstream flip-flops can use it as a clock enable. Their state then advances one step per press, and no logic is placed in their clock path.

The button level is first corrected for polarity, so that a pressed button reads as a high level. It then passes through a chain of synchronizing flip-flops. After that a four-state machine walks through a fixed cycle: idle, fire, cool-down, and wait-for-release. The 2-bit state code is exposed so that it can be shown on a display. A step-mode qualifier arms the machine. While the qualifier is low, the machine sits in idle and never fires.

Top module: `step_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block enters the idle state: `state` reads 0, `pulse` is low, and the synchronizer chain is cleared to "not pressed".
- R2: The state code is 0 for idle (waiting for a press), 1 for fire, 2 for cool-down, and 3 for waiting for release.
- R3: The corrected button level passes through SYNC_STAGES flip-flops (default 2). A press present before edge k, with the block idle and armed, gives `state` = 1 after edge k+SYNC_STAGES, which is three edges by default.
- R4: `pulse` is high exactly in the cycles in which `state` is 1. It is never high for two cycles in a row.
- R5: While armed, fire always moves to cool-down on the next edge, and cool-down always moves to wait-for-release on the next edge, whatever the button does.
- R6: Wait-for-release holds while the synchronized button stays pressed. It returns to idle on the first edge at which the synchronized button reads released.
- R7: A press held for any number of cycles produces exactly one pulse.
- R8: While `step_mode` is low at an edge, the next state is idle and no pulse is produced, even if a cycle is in progress.
- R9: With BTN_ACTIVE_LOW = 1 (the default), a low level on `btn_raw` means pressed. With 0, a high level means pressed.
- R10: A press shorter than the fire and cool-down states still completes the cycle. It passes through wait-for-release, gives one pulse, and then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_raw | input | 1 | Raw pushbutton level, polarity set by BTN_ACTIVE_LOW |
| step_mode | input | 1 | Qualifier; high arms the machine |
| pulse | output | 1 | One-cycle enable pulse per press |
| state | output | 2 | Current state code for display |

## Verification
Long and short presses show whether the machine fires once per press rather than once per cycle of hold. Short presses also show that fire and cool-down advance without regard to the button. Presses that arrive while step mode is low, or that are cut off by step mode falling in the middle of a cycle, separate the arming behaviour from the press detection. Random runs of button and mode levels are compared each cycle against a reference next-state function. Directed presses also pin down the exact press-to-pulse and release-to-idle latency through the synchronizer.

// File: rtl/step_pulse_pkg.sv
// Shared types for the single-step pulse generator.
// Assumes: the state codes are visible on a display and must not change.
package step_pulse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a press
        ST_FIRE = 2'd1,   // pulse cycle
        ST_COOL = 2'd2,   // pulse off, unconditional
        ST_HOLD = 2'd3    // waiting for release
    } pstate_e;

endpackage

// File: rtl/btn_condition.sv
// Polarity correction and multi-flop synchronizer for a pushbutton level.
// Assumes: btn_raw is asynchronous to clk; debouncing is handled elsewhere.
// The output is active high and lags the input by SYNC_STAGES edges.
module btn_condition #(
    parameter int SYNC_STAGES    = 2,
    parameter bit BTN_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic btn_sync
);

    logic               btn_corr;
    logic [SYNC_STAGES-1:0] stage;

    // Polarity variant picked by parameter.
    generate
        if (BTN_ACTIVE_LOW) begin : g_inv
            assign btn_corr = ~btn_raw;
        end else begin : g_pass
            assign btn_corr = btn_raw;
        end
    endgenerate

    // First synchronizer stage samples the corrected level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= btn_corr;
    end

    // Remaining stages shift the level along the chain.
    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 1'b0;
                else        stage[i] <= stage[i-1];
            end

            // R3: each stage takes the previous stage's value one edge later.
            assert_stage_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (stage[i] == $past(stage[i-1])));
        end
    endgenerate

    assign btn_sync = stage[SYNC_STAGES-1];

endmodule

// File: rtl/pulse_fsm.sv
// Four-state single-step machine: idle, fire, cool-down, wait-for-release.
// Assumes: btn is already synchronized and active high; arm is synchronous.
// The pulse is decoded from the fire state only.
module pulse_fsm
    import step_pulse_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    btn,
    input  logic    arm,
    output logic    pulse,
    output pstate_e cur
);

    pstate_e nxt;

    // Next-state selection; a disarmed machine always falls back to idle.
    always_comb begin
        nxt = ST_IDLE;
        if (arm) begin
            unique case (cur)
                ST_IDLE: nxt = btn ? ST_FIRE : ST_IDLE;
                ST_FIRE: nxt = ST_COOL;
                ST_COOL: nxt = ST_HOLD;
                ST_HOLD: nxt = btn ? ST_HOLD : ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

    // Pulse decode.
    assign pulse = (cur == ST_FIRE);

    // R1: reset lands in idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cur == ST_IDLE));

    // R4: the pulse never lasts two cycles.
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R3: a synchronized press seen in idle fires next.
    assert_press_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_IDLE && btn && arm) |=> (cur == ST_FIRE));

    // R5: fire and cool-down advance unconditionally while armed.
    assert_fire_to_cool_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_FIRE && arm) |=> (cur == ST_COOL));
    assert_cool_to_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_COOL && arm) |=> (cur == ST_HOLD));

    // R6: hold persists while pressed, exits when released.
    assert_hold_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_HOLD && btn && arm) |=> (cur == ST_HOLD));
    assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_HOLD && !btn) |=> (cur == ST_IDLE));

    // R8: a disarmed machine returns to idle without firing.
    assert_disarm_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cur == ST_IDLE && !pulse));

endmodule

// File: rtl/step_pulse_gen.sv
// Top level: pushbutton to one-cycle enable pulse, with state for display.
// Assumes: clk is the fast system clock; rst_n is synchronous, active low;
// step_mode is a synchronous level.
module step_pulse_gen
    import step_pulse_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter bit BTN_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_raw,
    input  logic       step_mode,
    output logic       pulse,
    output logic [1:0] state
);

    logic    btn_sync;
    pstate_e cur;

    btn_condition #(
        .SYNC_STAGES    (SYNC_STAGES),
        .BTN_ACTIVE_LOW (BTN_ACTIVE_LOW)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_raw  (btn_raw),
        .btn_sync (btn_sync)
    );

    pulse_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn_sync),
        .arm   (step_mode),
        .pulse (pulse),
        .cur   (cur)
    );

    // Expose the state code for display.
    assign state = cur;

endmodule

// File: tb/tb_step_pulse_gen.sv
module tb_step_pulse_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_raw = 1'b1;
    logic       step_mode = 1'b1;
    logic       pulse;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    // Reference model: corrected-button pipeline and state.
    bit       m_p1 = 1'b0, m_p2 = 1'b0;
    bit [1:0] m_st = 2'd0;

    always #10 clk = ~clk;

    step_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw),
        .step_mode(step_mode), .pulse(pulse), .state(state)
    );

    // Next state from R2, R5, R6, R8.
    function automatic bit [1:0] ref_next(bit [1:0] s, bit b, bit m);
        if (!m) return 2'd0;
        case (s)
            2'd0:    return b ? 2'd1 : 2'd0;
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return b ? 2'd3 : 2'd0;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(bit raw, bit mode, bit rst);
        bit [1:0] nx;
        btn_raw = raw; step_mode = mode; rst_n = rst;
        @(posedge clk);
        if (!rst) begin
            m_p1 = 0; m_p2 = 0; m_st = 0;
        end else begin
            nx   = ref_next(m_st, m_p2, mode);
            m_p2 = m_p1;
            m_p1 = ~raw;          // R9: active-low raw input
            m_st = nx;
        end
        @(negedge clk);
        if (pulse) pulses++;
        chk("R2 state", state, m_st);
        chk("R4 pulse", pulse, (m_st == 2'd1));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        void'($urandom(32'd20231));
        @(negedge clk);

        // R1: reset state
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R1 reset state", state, 0);
        chk("R1 reset pulse", pulse, 0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);

        // R9: released (raw high) gives no pulse
        pulses = 0;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1);
        chk("R9 raw high not pressed", pulses, 0);

        // R3: latency of three edges from press to fire
        lat = 0; pulses = 0;
        for (int i = 1; i <= 6 && pulses == 0; i++) begin
            step(1'b0, 1'b1, 1'b1);
            lat = i;
        end
        chk("R3 press latency", lat, 3);
        // R5: fire -> cool -> hold
        step(1'b0, 1'b1, 1'b1);
        chk("R5 cool", state, 2);
        step(1'b0, 1'b1, 1'b1);
        chk("R5 hold", state, 3);
        // R6 / R7: long hold, single pulse
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1);
        chk("R6 hold persists", state, 3);
        chk("R7 one pulse per long press", pulses, 1);
        // R6: release returns to idle after sync delay
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R6 still hold during sync", state, 3);
        step(1'b1, 1'b1, 1'b1);
        chk("R6 release idle", state, 0);

        // R10: one-cycle press
        pulses = 0;
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R10 short fire", state, 1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R10 short hold", state, 3);
        step(1'b1, 1'b1, 1'b1);
        chk("R10 short idle", state, 0);
        chk("R10 short pulses", pulses, 1);

        // R8: press while disarmed
        pulses = 0;
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1);
        chk("R8 disarmed pulses", pulses, 0);
        chk("R8 disarmed state", state, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
        // R8: disarm mid-cycle
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);
        chk("R8 reached hold", state, 3);
        step(1'b0, 1'b0, 1'b1);
        chk("R8 disarm aborts", state, 0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);

        // Random runs compared against the reference each cycle
        for (int r = 0; r < 600; r++) begin
            bit raw  = $urandom_range(0, 1);
            bit mode = ($urandom_range(0, 7) != 0);
            int len  = $urandom_range(1, 12);
            for (int k = 0; k < len; k++) step(raw, mode, 1'b1);
        end
        // R1: reset in mid-run
        step(1'b0, 1'b1, 1'b0);
        chk("R1 mid-run reset", state, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule